// File: doc/BRIEF.md
# Color LCD Controller Register Interface

This block is the software-facing register file of a color LCD controller. It sits on a simple 32-bit peripheral bus that reaches it through a word-aligned 4 KB window. Software uses it to program the panel timing words, the frame base addresses for the upper and lower panel halves, a control word, and the interrupt enables. From these stored values the block continuously derives the panel width in pixels, the panel height in lines, the pixel-depth code and a display-on flag. The pixel fetch engine and the timing generator consume these outputs. Both of them are outside this block.

The block keeps a raw interrupt status vector. Pulse inputs from the timing logic set its bits, and software writes to a clear register to remove them. A level interrupt output is asserted while any enabled status bit is pending. The top 32 bytes of the window return fixed identification bytes. Accesses that fall in the palette window are passed through to a separate palette block with a word index. A strap input selects an alternate address layout in which the control word and the interrupt-enable word trade places.

Accesses to undefined offsets do not stop the system. A read returns zero, a write changes nothing, and a one-cycle error flag is raised.

Top module: `lcdc_regs`

## Requirements
- R1: After synchronous reset, every stored register is zero. As a result, `irq` and `disp_on` are 0, `panel_width` is 16 and `panel_height` is 1.
- R2: The four timing words sit at byte offsets 0x000, 0x004, 0x008 and 0x00C. The upper base sits at 0x010 and the lower base at 0x014. Each of these reads back the last full 32-bit value written to it. Offsets 0x02C and 0x030 are read-only and return the upper and lower base respectively.
- R3: `panel_width` equals ((timing word 0 AND 0xFC) + 4) * 4.
- R4: `panel_height` equals (timing word 1 AND 0x3FF) + 1.
- R5: `disp_on` is 1 exactly when control bit 0 (enable) and control bit 11 (power) are both 1. `depth_code` equals control bits [3:1], where codes 0 to 5 mean 1, 2, 4, 8, 16 and 32 bits per pixel.
- R6: With `strap_swap` = 0, offset 0x018 is the interrupt-enable mask and offset 0x01C is control. With `strap_swap` = 1 the two offsets exchange roles, for both reads and writes.
- R7: Offset 0x020 reads the raw status and offset 0x024 reads raw AND mask, each zero-extended. `irq` is 1 exactly when raw AND mask is nonzero.
- R8: A 1 on `stat_set[i]` sets raw bit i. A write to offset 0x028 clears every raw bit whose written data bit is 1. When a set and a clear reach the same bit in the same cycle, the set wins. Reading 0x028 returns 0 without error.
- R9: A read of byte offset 0xFE0 + 4k (k = 0..7) returns, in bits [7:0], the byte 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 respectively, with the upper bits zero. The same bytes are returned in both strap settings.
- R10: For byte offsets 0x200 to 0x3FF, during the access cycle `pal_sel` is 1, `pal_wr` follows `bus_wr`, `pal_idx` is (offset - 0x200) >> 2 and `pal_wdata` is `bus_wdata`. A read returns `pal_rdata`. No local register changes, and `bus_err` stays 0.
- R11: Some accesses are invalid: any access to an undefined offset, and any write to a read-only offset (0x020, 0x024, 0x02C, 0x030 or the ID window). For these, `bus_err` is 1 for exactly the cycle after the access and a read returns 0. No register changes. Valid accesses leave `bus_err` at 0.
- R12: `bus_rdata` and `bus_err` are registered. They reflect an access one clock after it is presented, and `bus_rdata` holds its value between reads.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset inside the window (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle flag for an invalid access |
| strap_swap | input | 1 | Selects the swapped control/mask layout |
| stat_set | input | NIRQ | Status set pulses from the timing logic |
| irq | output | 1 | Level interrupt, raw AND mask nonzero |
| panel_width | output | 11 | Derived pixels per line |
| panel_height | output | 11 | Derived lines per panel |
| depth_code | output | 3 | Pixel-depth code |
| disp_on | output | 1 | Enable and power both set |
| top_base | output | 32 | Upper panel frame base |
| bot_base | output | 32 | Lower panel frame base |
| pal_sel | output | 1 | Palette window access strobe |
| pal_wr | output | 1 | Palette write |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data |

## Verification
Timing word 0 and timing word 1 are written with random values. Each derived width and height is compared to the formula. This shows that only the masked field bits feed the geometry, because the random upper bits must not change the result.

Control words are written with random enable and power combinations, in both strap settings. This separates a correct address swap from a design that decodes a single layout.

The status path is driven with set pulses, clears, and deliberate collisions of a set and a clear on the same bit. These show that the set wins and that the interrupt follows the mask.

Sweeps over the ID window, the palette window and undefined offsets confirm that each region returns only its own data and that invalid writes leave every stored register intact.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int GEOM_W   = 11;
    localparam int NTIM     = 4;
    localparam int PIDX_W   = 7;
    localparam int DEPTH_W  = 3;
    localparam int CTRL_EN  = 0;
    localparam int CTRL_PWR = 11;

    localparam logic [ADDR_W-1:0] PAL_LO = 12'h200;
    localparam logic [ADDR_W-1:0] PAL_HI = 12'h3FF;
    localparam logic [ADDR_W-1:0] ID_LO  = 12'hFE0;

    typedef enum logic [4:0] {
        K_TIM0    = 5'd0,
        K_TIM1    = 5'd1,
        K_TIM2    = 5'd2,
        K_TIM3    = 5'd3,
        K_TOP     = 5'd4,
        K_BOT     = 5'd5,
        K_MASK    = 5'd6,
        K_CTRL    = 5'd7,
        K_RAW     = 5'd8,
        K_MSTAT   = 5'd9,
        K_CLR     = 5'd10,
        K_CUR_TOP = 5'd11,
        K_CUR_BOT = 5'd12,
        K_ID      = 5'd13,
        K_PAL     = 5'd14,
        K_NONE    = 5'd15
    } reg_kind_e;

    typedef struct packed {
        logic [GEOM_W-1:0] width;
        logic [GEOM_W-1:0] height;
    } geom_t;

    function automatic logic [GEOM_W-1:0] width_of(input logic [DATA_W-1:0] t0);
        logic [GEOM_W-1:0] w;
        w = GEOM_W'({t0[7:2], 2'b00}) + GEOM_W'(4);
        return w << 2;
    endfunction

    function automatic logic [GEOM_W-1:0] height_of(input logic [DATA_W-1:0] t1);
        return GEOM_W'(t1[9:0]) + GEOM_W'(1);
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] k);
        case (k)
            3'd0:    return 8'h10;
            3'd1:    return 8'h11;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

    function automatic logic is_read_only(input reg_kind_e k);
        return (k == K_RAW) || (k == K_MSTAT) || (k == K_CUR_TOP) ||
               (k == K_CUR_BOT) || (k == K_ID);
    endfunction

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
    import lcdc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              swap,
    output reg_kind_e         kind,
    output logic [PIDX_W-1:0] pidx
);
    localparam int WORD_W = ADDR_W - 2;

    logic [ADDR_W-1:0] pal_off;
    logic [WORD_W-1:0] word;

    assign word    = addr[ADDR_W-1:2];
    assign pal_off = addr - PAL_LO;
    assign pidx    = pal_off[PIDX_W+1:2];

    always_comb begin
        kind = K_NONE;
        if (addr >= PAL_LO && addr <= PAL_HI) begin
            kind = K_PAL;
        end else if (addr >= ID_LO) begin
            kind = K_ID;
        end else begin
            case (word)
                10'd0:   kind = K_TIM0;
                10'd1:   kind = K_TIM1;
                10'd2:   kind = K_TIM2;
                10'd3:   kind = K_TIM3;
                10'd4:   kind = K_TOP;
                10'd5:   kind = K_BOT;
                10'd6:   kind = swap ? K_CTRL : K_MASK;
                10'd7:   kind = swap ? K_MASK : K_CTRL;
                10'd8:   kind = K_RAW;
                10'd9:   kind = K_MSTAT;
                10'd10:  kind = K_CLR;
                10'd11:  kind = K_CUR_TOP;
                10'd12:  kind = K_CUR_BOT;
                default: kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lcdc_cfg.sv
module lcdc_cfg
    import lcdc_pkg::*;
#(
    parameter int NIRQ = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  reg_kind_e                   kind,
    input  logic [DATA_W-1:0]           wdata,
    output logic [NTIM-1:0][DATA_W-1:0] tim,
    output logic [DATA_W-1:0]           top,
    output logic [DATA_W-1:0]           bot,
    output logic [DATA_W-1:0]           ctrl,
    output logic [NIRQ-1:0]             mask
);
    for (genvar i = 0; i < NTIM; i++) begin : g_tim
        always_ff @(posedge clk) begin
            if (rst) begin
                tim[i] <= '0;
            end else if (we && int'(kind) == i) begin
                tim[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top  <= '0;
            bot  <= '0;
            ctrl <= '0;
            mask <= '0;
        end else if (we) begin
            case (kind)
                K_TOP:   top  <= wdata;
                K_BOT:   bot  <= wdata;
                K_CTRL:  ctrl <= wdata;
                K_MASK:  mask <= wdata[NIRQ-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq #(
    parameter int NIRQ = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] set_p,
    input  logic            clr_en,
    input  logic [NIRQ-1:0] clr_bits,
    input  logic [NIRQ-1:0] mask,
    output logic [NIRQ-1:0] raw,
    output logic [NIRQ-1:0] masked,
    output logic            irq
);
    for (genvar i = 0; i < NIRQ; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                raw[i] <= 1'b0;
            end else if (set_p[i]) begin
                raw[i] <= 1'b1;
            end else if (clr_en && clr_bits[i]) begin
                raw[i] <= 1'b0;
            end
        end
    end

    assign masked = raw & mask;
    assign irq    = |masked;
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
    import lcdc_pkg::*;
#(
    parameter int NIRQ = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic              strap_swap,
    input  logic [NIRQ-1:0]   stat_set,
    output logic              irq,
    output logic [10:0]       panel_width,
    output logic [10:0]       panel_height,
    output logic [2:0]        depth_code,
    output logic              disp_on,
    output logic [31:0]       top_base,
    output logic [31:0]       bot_base,
    output logic              pal_sel,
    output logic              pal_wr,
    output logic [6:0]        pal_idx,
    output logic [31:0]       pal_wdata,
    input  logic [31:0]       pal_rdata
);
    reg_kind_e                   kind;
    logic [PIDX_W-1:0]           pidx;
    logic [NTIM-1:0][DATA_W-1:0] tim;
    logic [DATA_W-1:0]           ctrl;
    logic [NIRQ-1:0]             int_mask;
    logic [NIRQ-1:0]             raw_stat;
    logic [NIRQ-1:0]             masked;
    logic                        bad_acc;
    logic                        reg_we;
    logic [DATA_W-1:0]           rd_val;
    geom_t                       geom;

    lcdc_decode u_dec (
        .addr (bus_addr),
        .swap (strap_swap),
        .kind (kind),
        .pidx (pidx)
    );

    assign bad_acc = bus_sel && ((kind == K_NONE) || (bus_wr && is_read_only(kind)));
    assign reg_we  = bus_sel && bus_wr && !bad_acc;

    lcdc_cfg #(.NIRQ(NIRQ)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .kind  (kind),
        .wdata (bus_wdata),
        .tim   (tim),
        .top   (top_base),
        .bot   (bot_base),
        .ctrl  (ctrl),
        .mask  (int_mask)
    );

    lcdc_irq #(.NIRQ(NIRQ)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_p    (stat_set),
        .clr_en   (reg_we && kind == K_CLR),
        .clr_bits (bus_wdata[NIRQ-1:0]),
        .mask     (int_mask),
        .raw      (raw_stat),
        .masked   (masked),
        .irq      (irq)
    );

    assign geom.width   = width_of(tim[0]);
    assign geom.height  = height_of(tim[1]);
    assign panel_width  = geom.width;
    assign panel_height = geom.height;
    assign depth_code   = ctrl[DEPTH_W:1];
    assign disp_on      = ctrl[CTRL_EN] && ctrl[CTRL_PWR];

    assign pal_sel   = bus_sel && (kind == K_PAL);
    assign pal_wr    = pal_sel && bus_wr;
    assign pal_idx   = pidx;
    assign pal_wdata = bus_wdata;

    always_comb begin
        case (kind)
            K_TIM0, K_TIM1,
            K_TIM2, K_TIM3:       rd_val = tim[kind[1:0]];
            K_TOP, K_CUR_TOP:     rd_val = top_base;
            K_BOT, K_CUR_BOT:     rd_val = bot_base;
            K_MASK:               rd_val = DATA_W'(int_mask);
            K_CTRL:               rd_val = ctrl;
            K_RAW:                rd_val = DATA_W'(raw_stat);
            K_MSTAT:              rd_val = DATA_W'(masked);
            K_ID:                 rd_val = DATA_W'(id_byte(bus_addr[4:2]));
            K_PAL:                rd_val = pal_rdata;
            default:              rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= bad_acc;
            if (bus_sel && !bus_wr) begin
                bus_rdata <= rd_val;
            end
        end
    end
endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk #(
    parameter int NIRQ = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_sel,
    input logic            bus_wr,
    input logic            bus_err,
    input logic            irq,
    input logic            disp_on,
    input logic            pal_sel,
    input logic [31:0]     top_base,
    input logic [NIRQ-1:0] stat_set,
    input logic [NIRQ-1:0] raw_stat,
    input logic [NIRQ-1:0] int_mask
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && !disp_on && !bus_err));

    // R8
    set_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (|stat_set) |=> ((raw_stat & $past(stat_set)) == $past(stat_set)));

    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|int_mask));

    // R11
    err_follows_access_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_sel));

    // R11
    bad_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_err && $past(bus_wr)) |-> $stable(top_base));

    // R10
    pal_only_on_access_chk: assert property (@(posedge clk) disable iff (rst)
        pal_sel |-> bus_sel);

    // R5
    disp_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(disp_on) |-> $past(bus_sel && bus_wr));
endmodule

bind lcdc_regs lcdc_regs_chk #(.NIRQ(NIRQ)) chk_i (.*);

// File: tb/lcdc_regs_tb_top.sv
module lcdc_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            bus_err;
    logic            strap_swap = 1'b0;
    logic [NIRQ-1:0] stat_set = '0;
    logic            irq;
    logic [10:0]     panel_width;
    logic [10:0]     panel_height;
    logic [2:0]      depth_code;
    logic            disp_on;
    logic [31:0]     top_base;
    logic [31:0]     bot_base;
    logic            pal_sel;
    logic            pal_wr;
    logic [6:0]      pal_idx;
    logic [31:0]     pal_wdata;
    logic [31:0]     pal_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0]     m_tim0 = '0, m_tim1 = '0, m_ctrl = '0;
    logic [NIRQ-1:0] m_mask = '0, m_raw = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pal_rdata = 32'hC0DE_0000 | 32'(pal_idx);

    lcdc_regs #(.NIRQ(NIRQ)) dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [10:0] exp_w(input logic [31:0] v);
        return 11'(((v & 32'hFC) + 32'd4) * 32'd4);
    endfunction

    function automatic logic [10:0] exp_h(input logic [31:0] v);
        return 11'((v & 32'h3FF) + 32'd1);
    endfunction

    function automatic logic [7:0] exp_id(input int k);
        logic [7:0] t [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return t[k];
    endfunction

    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic err);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd = bus_rdata; err = bus_err;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] r; logic e;
        access(1'b1, a, d, r, e);
        chk("R11 valid write no err", 32'(e), 32'd0);
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] r; logic e;
        access(1'b0, a, 32'h0, r, e);
        chk(tag, r, exp);
    endtask

    task automatic chk_geom_ctrl();
        chk("R3 width", 32'(panel_width), 32'(exp_w(m_tim0)));
        chk("R4 height", 32'(panel_height), 32'(exp_h(m_tim1)));
        chk("R5 disp_on", 32'(disp_on), 32'(m_ctrl[0] & m_ctrl[11]));
        chk("R5 depth", 32'(depth_code), 32'(m_ctrl[3:1]));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] r, v;
        logic e;
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 width", 32'(panel_width), 16);
        chk("R1 height", 32'(panel_height), 1);
        chk("R1 disp_on", 32'(disp_on), 0);
        chk("R1 top", top_base, 0);
        rd("R1 ctrl read", 12'h01C, 0);

        // R2 read-back, R12 hold
        wr(12'h008, 32'hDEAD_BEEF); wr(12'h00C, 32'h1234_5678);
        wr(12'h010, 32'hA000_0000); wr(12'h014, 32'hB000_0040);
        rd("R2 tim2", 12'h008, 32'hDEAD_BEEF);
        rd("R2 tim3", 12'h00C, 32'h1234_5678);
        rd("R2 top", 12'h010, 32'hA000_0000);
        rd("R2 bot", 12'h014, 32'hB000_0040);
        rd("R2 cur top", 12'h02C, 32'hA000_0000);
        rd("R2 cur bot", 12'h030, 32'hB000_0040);
        chk("R2 top port", top_base, 32'hA000_0000);
        chk("R2 bot port", bot_base, 32'hB000_0040);
        wr(12'h008, 32'h0);
        @(negedge clk);
        chk("R12 rdata held", bus_rdata, 32'hB000_0040);

        // R3 R4 boundaries
        m_tim0 = 32'hFFFF_FFFF; wr(12'h000, m_tim0); chk_geom_ctrl();
        m_tim1 = 32'hFFFF_FC00; wr(12'h004, m_tim1); chk_geom_ctrl();
        m_tim1 = 32'h0000_03FF; wr(12'h004, m_tim1); chk_geom_ctrl();

        // random timing/control, normal layout (R3 R4 R5 R6)
        for (int i = 0; i < 60; i++) begin
            m_tim0 = $urandom; wr(12'h000, m_tim0);
            m_tim1 = $urandom; wr(12'h004, m_tim1);
            m_ctrl = $urandom; wr(12'h01C, m_ctrl);
            chk_geom_ctrl();
            rd("R2 tim0", 12'h000, m_tim0);
            rd("R6 ctrl at 0x1C", 12'h01C, m_ctrl);
        end
        m_ctrl = 32'h0000_0801; wr(12'h01C, m_ctrl); chk_geom_ctrl();
        m_ctrl = 32'h0000_0800; wr(12'h01C, m_ctrl); chk_geom_ctrl();
        m_ctrl = 32'h0000_0001; wr(12'h01C, m_ctrl); chk_geom_ctrl();
        m_mask = 4'b0101; wr(12'h018, 32'hFFFF_FFF5);
        rd("R6 mask at 0x18", 12'h018, 32'(m_mask));

        // swapped layout R6
        strap_swap = 1'b1;
        rd("R6 swap ctrl at 0x18", 12'h018, m_ctrl);
        rd("R6 swap mask at 0x1C", 12'h01C, 32'(m_mask));
        for (int i = 0; i < 20; i++) begin
            m_ctrl = $urandom; wr(12'h018, m_ctrl);
            m_mask = 4'($urandom); wr(12'h01C, 32'(m_mask));
            chk_geom_ctrl();
            rd("R6 swap ctrl", 12'h018, m_ctrl);
        end
        for (int k = 0; k < 8; k++) rd("R9 id swap", 12'hFE0 + 12'(4*k), 32'(exp_id(k)));
        strap_swap = 1'b0;
        rd("R6 unswapped mask", 12'h018, 32'(m_mask));

        // R7 R8 random interrupt traffic
        for (int i = 0; i < 80; i++) begin
            int op = int'($urandom % 3);
            if (op == 0) begin
                v = 32'($urandom % 16);
                @(negedge clk); stat_set = v[3:0];
                @(negedge clk); stat_set = '0;
                m_raw = m_raw | v[3:0];
            end else if (op == 1) begin
                v = $urandom; wr(12'h028, v);
                m_raw = m_raw & ~v[3:0];
            end else begin
                m_mask = 4'($urandom); wr(12'h018, 32'(m_mask));
            end
            chk("R7 irq", 32'(irq), 32'(|(m_raw & m_mask)));
            rd("R7 raw", 12'h020, 32'(m_raw));
            rd("R7 masked", 12'h024, 32'(m_raw & m_mask));
        end
        // R8 set beats clear
        m_raw = 4'b0000; wr(12'h028, 32'hF);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h028; bus_wdata = 32'hF; stat_set = 4'b1001;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; stat_set = '0;
        rd("R8 set wins", 12'h020, 32'h9);
        rd("R8 clr read zero", 12'h028, 0);

        // R9 ID window
        for (int k = 0; k < 8; k++) rd("R9 id", 12'hFE0 + 12'(4*k), 32'(exp_id(k)));

        // R10 palette
        for (int i = 0; i < 16; i++) begin
            logic [11:0] a;
            a = 12'h200 + 12'(4 * ($urandom % 128));
            v = $urandom;
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'(i % 2); bus_addr = a; bus_wdata = v;
            #1;
            chk("R10 pal_sel", 32'(pal_sel), 1);
            chk("R10 pal_wr", 32'(pal_wr), 32'(i % 2));
            chk("R10 pal_idx", 32'(pal_idx), 32'((a - 12'h200) >> 2));
            chk("R10 pal_wdata", pal_wdata, v);
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0;
            chk("R10 no err", 32'(bus_err), 0);
            if (i % 2 == 0) chk("R10 read data", bus_rdata, 32'hC0DE_0000 | ((32'(a) - 32'h200) >> 2));
        end
        rd("R10 top untouched", 12'h010, 32'hA000_0000);

        // R11 undefined and read-only
        access(1'b0, 12'h040, 32'h0, r, e);
        chk("R11 undef read data", r, 0); chk("R11 undef read err", 32'(e), 1);
        @(negedge clk);
        chk("R11 err one cycle", 32'(bus_err), 0);
        access(1'b1, 12'h500, 32'hFFFF_FFFF, r, e);
        chk("R11 undef write err", 32'(e), 1);
        access(1'b1, 12'h020, 32'hFFFF_FFFF, r, e);
        chk("R11 ro write err", 32'(e), 1);
        access(1'b1, 12'hFE0, 32'hFFFF_FFFF, r, e);
        chk("R11 id write err", 32'(e), 1);
        rd("R11 id intact", 12'hFE0, 32'h10);
        rd("R11 raw intact", 12'h020, 32'h9);
        rd("R11 top intact", 12'h010, 32'hA000_0000);
        rd("R11 tim0 intact", 12'h000, m_tim0);
        rd("R11 ctrl intact", 12'h01C, m_ctrl);

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule